// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 16-bit successive-approximation converter. A falling edge on the active-low request input is brought into the conversion clock domain. Once the track/hold window since the previous conversion has been served, the sequencer walks a trial code from the most significant position down to the least, one position per clock. At each position it keeps or clears the trial bit according to a one-bit comparator input. The capacitor array and comparator sit outside the block. They receive the trial code and return `cmp_below`, which is high when the balance node lies below zero.

While the bits are being decided they stream out on `sdo`, framed by `bit_frame`. A system can capture them without waiting for the end. The full code is also latched into a holding register together with a one-clock `done` pulse. A mode input selects straight binary for a unipolar range or two's complement for a bipolar range. Tying `req_n` to `bit_frame` makes the block convert back to back at full rate.

Top module: `sar_sequencer`

## Requirements
- R1: Each conversion decides NBITS=16 bits, MSB first, one per clock. The `trial` output holds the bits decided so far, a 1 at the position under test and 0 below it. A bit is kept as 1 exactly when `cmp_below` is high while that position is under test.
- R2: `req_n` passes a two-stage synchroniser and only its falling edge counts. When the block is idle and the acquisition window has been served, `bit_frame` goes high after the fourth rising edge, counting the first edge that samples `req_n` low as the first.
- R3: After the edge that decides the last bit, at least ACQ_CLKS=3 more clocks must pass. A conversion therefore starts no earlier than the fourth edge after it, and `bit_frame` stays low for at least 4 cycles between frames. A request that arrives before then is held and served at that edge, not dropped.
- R4: `bit_frame` rises one clock after a conversion starts and falls one clock after the last decision. It is high for exactly 16 cycles per conversion and low at all other times.
- R5: `sdo` carries each decided bit during the `bit_frame` cycle that follows its decision, MSB first, and is 0 while `bit_frame` is low.
- R6: With `bipolar` high, `result` and the `sdo` stream are in two's complement: the MSB is the complement of the MSB decision. `trial` stays in offset binary. With `bipolar` low, all three use straight binary.
- R7: `bipolar` is captured when a conversion starts. A change during the conversion has no effect on that conversion.
- R8: A synchronised falling edge of `req_n` that appears while a conversion is running is ignored and starts nothing afterwards.
- R9: `result` loads at the last decision and holds otherwise. `done` is high for exactly one clock, the cycle in which `sdo` carries the LSB.
- R10: With `req_n` driven from `bit_frame`, conversions repeat every 20 clocks: 16 cycles with `bit_frame` high, then 4 with it low.
- R11: While `rst_n` is low, `bit_frame`, `sdo`, `done`, `result` and `trial` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Convert request, active low, asynchronous; its falling edge counts |
| bipolar | input | 1 | 1 = two's-complement output coding, 0 = straight binary |
| cmp_below | input | 1 | Comparator: 1 = balance node below zero, keep the trial bit |
| trial | output | NBITS | Trial code to the DAC, offset binary |
| bit_frame | output | 1 | High while `sdo` carries valid result bits |
| sdo | output | 1 | Serial result bit, MSB first |
| result | output | NBITS | Latched result of the last conversion |
| done | output | 1 | One-clock pulse when `result` loads |

## Verification
The hardest case to reach is a request that lands near the end of a conversion. Its synchronised edge must appear only after the last decision, while the acquisition counter is still short of its limit. The bench raises `req_n` early in a frame and drops it again one cycle before the last decision. This puts the edge into the first idle cycles, so the held request must be served exactly on the fourth edge after the frame. A second directed case pulses the request entirely inside a frame to show that it is dropped.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } seq_state_t;
endpackage

// File: rtl/sar_req_sync.sv
// Brings the asynchronous request into the clock domain and flags its falling edge.
module sar_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   output logic req_fall
);
   logic [STAGES:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "sar_req_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], req_n};
   end

   // the extra stage past the synchroniser holds the previous level
   assign req_fall = chain_q[STAGES] & ~chain_q[STAGES-1];

   a_r2_fall_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_fall |=> !req_fall);
endmodule

// File: rtl/sar_acq_timer.sv
// Counts clocks since the last decision and saturates at the acquisition limit.
module sar_acq_timer #(
   parameter int ACQ_CLKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic ready
);
   localparam int CW = $clog2(ACQ_CLKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(ACQ_CLKS);

   logic [CW-1:0] cnt_q;

   if (ACQ_CLKS < 1) begin : g_bad_acq
      initial $fatal(1, "sar_acq_timer: ACQ_CLKS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= LIMIT;
      else if (clear)          cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
   end

   assign ready = (cnt_q == LIMIT);

   a_r3_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !ready);
endmodule

// File: rtl/sar_trial_reg.sv
// Decided-bit register plus one-hot position pointer forming the trial code.
module sar_trial_reg #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             cmp_below,
   output logic [NBITS-1:0] trial,
   output logic [NBITS-1:0] code_next,
   output logic             at_msb,
   output logic             at_lsb
);
   localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};
   localparam logic [NBITS-1:0] ONE     = {{(NBITS-1){1'b0}}, 1'b1};

   logic [NBITS-1:0] dec_q;
   logic [NBITS-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q <= '0;
         ptr_q <= '0;
      end else if (load) begin
         dec_q <= '0;
         ptr_q <= TOP_BIT;
      end else if (step) begin
         dec_q <= code_next;
         ptr_q <= ptr_q >> 1;
      end
   end

   assign trial     = dec_q | ptr_q;
   assign code_next = cmp_below ? trial : dec_q;
   assign at_msb    = ptr_q[NBITS-1];
   assign at_lsb    = ptr_q[0];

   a_r1_ptr_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr_q));
   a_r1_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q != '0) |-> ((dec_q & ((ptr_q << 1) - ONE)) == '0));
   a_r1_ptr_walks: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !at_lsb && ptr_q != '0) |=> (ptr_q == ($past(ptr_q) >> 1)));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
   parameter int NBITS       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACQ_CLKS    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_n,
   input  logic             bipolar,
   input  logic             cmp_below,
   output logic [NBITS-1:0] trial,
   output logic             bit_frame,
   output logic             sdo,
   output logic [NBITS-1:0] result,
   output logic             done
);
   import sar_seq_pkg::*;

   localparam logic [NBITS-1:0] SIGN_MASK = {1'b1, {(NBITS-1){1'b0}}};

   if (NBITS < 2) begin : g_bad_width
      initial $fatal(1, "sar_sequencer: NBITS must be at least 2");
   end

   seq_state_t       state_q;
   logic             pend_q, bip_q, frame_q, sdo_q, done_q;
   logic [NBITS-1:0] result_q;
   logic             req_fall, acq_ready, at_msb, at_lsb;
   logic [NBITS-1:0] code_next;
   logic             busy, req_hit, start, finish, out_bit;

   sar_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .req_fall(req_fall));

   sar_acq_timer #(.ACQ_CLKS(ACQ_CLKS)) u_acq (
      .clk(clk), .rst_n(rst_n), .clear(finish), .ready(acq_ready));

   sar_trial_reg #(.NBITS(NBITS)) u_trial (
      .clk(clk), .rst_n(rst_n), .load(start), .step(busy),
      .cmp_below(cmp_below), .trial(trial), .code_next(code_next),
      .at_msb(at_msb), .at_lsb(at_lsb));

   assign busy    = (state_q == ST_CONV);
   assign req_hit = req_fall | pend_q;
   assign start   = !busy && req_hit && acq_ready;
   assign finish  = busy && at_lsb;
   assign out_bit = cmp_below ^ (bip_q & at_msb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pend_q   <= 1'b0;
         bip_q    <= 1'b0;
         frame_q  <= 1'b0;
         sdo_q    <= 1'b0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         if (start)       state_q <= ST_CONV;
         else if (finish) state_q <= ST_IDLE;
         // edges that show up mid-conversion are dropped here
         pend_q  <= !busy && !start && req_hit;
         if (start) bip_q <= bipolar;
         frame_q <= busy;
         sdo_q   <= busy ? out_bit : 1'b0;
         done_q  <= finish;
         if (finish) result_q <= code_next ^ (bip_q ? SIGN_MASK : '0);
      end
   end

   assign bit_frame = frame_q;
   assign sdo       = sdo_q;
   assign result    = result_q;
   assign done      = done_q;

   a_r4_frame_ends_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_q) |-> $past(done_q));
   a_r3_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_q) |-> (!$past(done_q, 1) && !$past(done_q, 2) && !$past(done_q, 3)));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(result_q));
   a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !at_lsb) |=> busy);
   a_r5_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_q |-> !sdo_q);
endmodule

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_drv = 1'b1;
   logic        loop_en = 1'b0;
   logic        bip_in = 1'b0;
   logic        model_bip = 1'b0;
   logic [15:0] samp = '0;
   logic        req_n, cmp_below, bit_frame, sdo, done;
   logic [15:0] trial, result;
   int          n_chk = 0;
   int          n_err = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   assign req_n     = loop_en ? bit_frame : conv_drv;
   // comparator model: node below zero when held sample reaches the offset-binary trial
   assign cmp_below = ((model_bip ? (samp ^ 16'h8000) : samp) >= trial);

   sar_sequencer i_sar_sequencer (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .bipolar(bip_in),
      .cmp_below(cmp_below), .trial(trial), .bit_frame(bit_frame),
      .sdo(sdo), .result(result), .done(done));

   // {bipolar, sample}; expected result equals the sample in both codings
   localparam logic [16:0] VEC [9] = '{
      17'h0_0000, 17'h0_FFFF, 17'h0_8000, 17'h0_7FFF, 17'h0_1234,
      17'h1_8000, 17'h1_7FFF, 17'h1_0000, 17'h1_FFFF };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_rise(output int lows);
      lows = 0;
      while (bit_frame !== 1'b1 && lows < 64) begin
         lows++;
         @(negedge clk);
      end
   endtask

   // called at a negedge where bit_frame is high; mode selects a mid-frame action
   task automatic frame(input logic [15:0] exp, input string req, input int mode);
      logic [15:0] stream;
      int highs;
      highs = 0;
      stream = '0;
      for (int i = 0; i < 16; i++) begin
         if (bit_frame === 1'b1) highs++;
         stream[15-i] = sdo;
         if (i == 15) check(done === 1'b1, "R9", "done on LSB cycle", {31'b0, done}, 1);
         else if (done !== 1'b0) check(1'b0, "R9", "early done", {31'b0, done}, 0);
         if (mode == 1 && i == 3) bip_in = ~bip_in;
         if (mode == 2 && i == 4) conv_drv = 1'b1;
         if (mode == 2 && i == 8) conv_drv = 1'b0;
         if (mode == 3 && i == 2) conv_drv = 1'b1;
         if (mode == 3 && i == 14) conv_drv = 1'b0;
         if (mode == 4 && i == 5) loop_en = 1'b0;
         @(negedge clk);
      end
      check(highs == 16, "R4", "frame length", highs, 16);
      check(bit_frame === 1'b0, "R4", "frame falls", {31'b0, bit_frame}, 0);
      check(result === exp, req, "result", {16'b0, result}, {16'b0, exp});
      check(stream === exp, "R5", "serial stream", {16'b0, stream}, {16'b0, exp});
      check(done === 1'b0, "R9", "done single", {31'b0, done}, 0);
   endtask

   task automatic start_req(input logic b, input logic [15:0] s, output int lows);
      model_bip = b;
      bip_in = b;
      samp = s;
      @(posedge clk);
      #1 conv_drv = 1'b0;
      @(negedge clk);
      wait_rise(lows);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int lows;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(bit_frame === 1'b0 && sdo === 1'b0 && done === 1'b0, "R11", "flags in reset",
            {29'b0, bit_frame, sdo, done}, 0);
      check(result === 16'h0 && trial === 16'h0, "R11", "registers in reset",
            {result, trial}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // table walk: R1 unipolar, R6 bipolar, R2 latency
      for (int v = 0; v < 9; v++) begin
         start_req(VEC[v][16], VEC[v][15:0], lows);
         check(lows == 4, "R2", "request latency", lows, 4);
         frame(VEC[v][15:0], VEC[v][16] ? "R6" : "R1", 0);
         conv_drv = 1'b1;
         repeat (6) @(negedge clk);
      end

      // R7: mode flipped mid-conversion must not matter
      start_req(1'b0, 16'h0F0F, lows);
      frame(16'h0F0F, "R7", 1);
      bip_in = 1'b0;
      conv_drv = 1'b1;
      repeat (6) @(negedge clk);

      // R8: request pulse fully inside a conversion is dropped
      start_req(1'b0, 16'hA5A5, lows);
      frame(16'hA5A5, "R1", 2);
      lows = 0;
      for (int i = 0; i < 12; i++) begin
         if (bit_frame === 1'b1) lows++;
         @(negedge clk);
      end
      check(lows == 0, "R8", "no restart after in-frame request", lows, 0);
      conv_drv = 1'b1;
      repeat (6) @(negedge clk);

      // R3: request landing right after the last decision is held until acquisition ends
      start_req(1'b0, 16'h3C3C, lows);
      frame(16'h3C3C, "R1", 3);
      wait_rise(lows);
      check(lows == 4, "R3", "held request gap", lows, 4);
      frame(16'h3C3C, "R3", 0);
      conv_drv = 1'b1;
      repeat (6) @(negedge clk);

      // R10: request tied to the frame output
      model_bip = 1'b1;
      bip_in = 1'b1;
      samp = 16'hC001;
      loop_en = 1'b1;
      @(negedge clk);
      wait_rise(lows);
      for (int f = 0; f < 3; f++) begin
         frame(16'hC001, "R10", (f == 2) ? 4 : 0);
         if (f < 2) begin
            wait_rise(lows);
            check(lows == 4, "R10", "back-to-back gap", lows, 4);
         end
      end
      lows = 0;
      for (int i = 0; i < 10; i++) begin
         if (bit_frame === 1'b1) lows++;
         @(negedge clk);
      end
      check(lows == 0, "R10", "loop stops when untied", lows, 0);

      // R11: reset in the middle of a conversion
      start_req(1'b0, 16'h5555, lows);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(bit_frame === 1'b0 && sdo === 1'b0 && done === 1'b0, "R11", "flags after reset",
            {29'b0, bit_frame, sdo, done}, 0);
      check(result === 16'h0 && trial === 16'h0, "R11", "registers after reset",
            {result, trial}, 0);
      conv_drv = 1'b1;
      repeat (3) @(negedge clk);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule